// File: doc/BRIEF.md
# Multiplexed Parallel Register Port

This block is the slave side of a narrow parallel register interface. A host reaches a small bank of byte-wide registers over one shared bus that carries an address and then a data byte. The bus is clocked by the host's port clock and qualified by a select strobe and a read/not-write strobe. Every access takes three rising port-clock edges with select held high. The first edge captures the address and the direction. The second edge captures the write byte, or turns the bus around so the port can drive read data. The third edge closes the access. Dropping select before the third edge aborts the access.

Writes only reach a buffer register. The registers seen by the downstream core change only when the host raises the update strobe. On that edge every buffer value is copied into the active set at once, so a group of related settings takes effect together. Reads return the buffer contents. This lets a host check a staged value before it applies it.

Top module: `ppt_port`

## Requirements
- R1: At the first rising edge of `pclk` with `sel_i` high while the port is idle, the port captures `bus_i` as the register address and `rnw_i` as the direction (1 = read). Later changes of `rnw_i` within that access have no effect.
- R2: For a write, the byte on `bus_i` at the second edge is captured. It is stored in the addressed buffer register at the third edge, and only if `sel_i` is still high there.
- R3: For a read, `bus_oe` is 1 from just after the second edge until the third edge. During that window `bus_o` carries the addressed buffer byte.
- R4: `bus_oe` is 0 during every address phase and during every write access. Whenever `bus_oe` is 0, `bus_o` is 0x00.
- R5: If `sel_i` is low at the second or third edge of an access, the access is dropped: no buffer register changes and the port returns to idle. `bus_oe` falls in the same cycle that `sel_i` falls, without waiting for a clock edge.
- R6: The active registers change only at a rising edge where `upd_i` is 1. At that edge each active register takes the buffer value it held just before the edge.
- R7: A read returns the buffer value, so a write that has not been applied can be read back before the update.
- R8: Addresses at or above `NREG` read as 0x00, and writes to them change no register.
- R9: With `rst_n` low at a clock edge, all buffer and active registers clear to 0x00 and the sequencer returns to idle.
- R10: Active register k appears on `regs_o[8k+7:8k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Port clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_i | input | 1 | Access select, active high |
| rnw_i | input | 1 | Direction, sampled at the first edge: 1 read, 0 write |
| bus_i | input | DW | Shared bus as seen by the port (address, then write data) |
| bus_o | output | DW | Read data driven toward the shared bus |
| bus_oe | output | 1 | Enable for `bus_o` onto the shared bus |
| upd_i | input | 1 | Update strobe: copies buffer registers into active registers |
| regs_o | output | NREG*DW | Flat active register image, register k at bits [DW*k+DW-1:DW*k] |

## Verification
The bench builds the port with `NREG` = 6, which is not a power of two. Random addresses are drawn from 0 to 9. This reaches addresses that fit the index width but lie beyond the bank (6 and 7), so the range comparison is tested separately from index truncation. It also reaches addresses wider than the index. Together with random aborts at either edge, read-before-update sequences, and a direction strobe that flips during the data phase, the staging and turnaround rules are covered under many interleavings.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
    // Access phase: idle, address taken (edge 1 done), data taken (edge 2 done)
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } ph_e;
endpackage

// File: rtl/ppt_seq.sv
module ppt_seq
    import ppt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          rnw,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] addr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          oe
);
    typedef struct packed {
        ph_e           ph;
        logic          rd;
        logic [DW-1:0] addr;
        logic [DW-1:0] data;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        wr_en = 1'b0;
        unique case (seq_q.ph)
            PH_IDLE: begin
                if (sel) begin
                    seq_d.ph   = PH_ADDR;
                    seq_d.addr = bus_in;
                    seq_d.rd   = rnw;
                end
            end
            PH_ADDR: begin
                if (sel) begin
                    seq_d.ph = PH_DATA;
                    if (!seq_q.rd) seq_d.data = bus_in;
                end else begin
                    seq_d.ph = PH_IDLE;
                end
            end
            PH_DATA: begin
                wr_en    = sel && !seq_q.rd;
                seq_d.ph = PH_IDLE;
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_IDLE, rd: 1'b0, addr: '0, data: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign addr    = seq_q.addr;
    assign wr_data = seq_q.data;
    assign oe      = (seq_q.ph == PH_DATA) && seq_q.rd && sel;

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph != PH_IDLE && !sel) |=> (seq_q.ph == PH_IDLE)); // R5

    AST_OE_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> ($past(seq_q.ph) == PH_ADDR && $past(sel))); // R3

    AST_WR_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(seq_q.ph) == PH_ADDR && $past(sel) && !oe)); // R2
endmodule

// File: rtl/ppt_regbank.sv
module ppt_regbank #(
    parameter int DW   = 8,
    parameter int NREG = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [DW-1:0]            addr,
    input  logic [DW-1:0]            wr_data,
    input  logic                     upd,
    output logic [DW-1:0]            rd_data,
    output logic [NREG-1:0][DW-1:0]  act
);
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] bufr;
        logic [NREG-1:0][DW-1:0] act;
    } bank_t;

    bank_t          bank_d, bank_q;
    logic           in_range;
    logic [IW-1:0]  idx;

    assign in_range = (addr < DW'(NREG));
    assign idx      = addr[IW-1:0];

    always_comb begin
        bank_d = bank_q;
        if (upd) bank_d.act = bank_q.bufr;
        if (wr_en && in_range) bank_d.bufr[idx] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_data = in_range ? bank_q.bufr[idx] : '0;
    assign act     = bank_q.act;

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(bank_q.act)); // R6

    AST_ACT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (bank_q.act == $past(bank_q.bufr))); // R6

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_q.bufr)); // R5

    AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_range) |=> $stable(bank_q.bufr)); // R8
endmodule

// File: rtl/ppt_port.sv
module ppt_port #(
    parameter int DW   = 8,
    parameter int NREG = 8
) (
    input  logic               pclk,
    input  logic               rst_n,
    input  logic               sel_i,
    input  logic               rnw_i,
    input  logic [DW-1:0]      bus_i,
    output logic [DW-1:0]      bus_o,
    output logic               bus_oe,
    input  logic               upd_i,
    output logic [NREG*DW-1:0] regs_o
);
    logic [DW-1:0]           acc_addr;
    logic                    wr_en;
    logic [DW-1:0]           wr_data;
    logic                    oe;
    logic [DW-1:0]           rd_data;
    logic [NREG-1:0][DW-1:0] act;

    ppt_seq #(.DW(DW)) u_seq (
        .clk     (pclk),
        .rst_n   (rst_n),
        .sel     (sel_i),
        .rnw     (rnw_i),
        .bus_in  (bus_i),
        .addr    (acc_addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .oe      (oe)
    );

    ppt_regbank #(.DW(DW), .NREG(NREG)) u_bank (
        .clk     (pclk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (acc_addr),
        .wr_data (wr_data),
        .upd     (upd_i),
        .rd_data (rd_data),
        .act     (act)
    );

    assign bus_oe = oe;
    assign bus_o  = oe ? rd_data : '0;
    assign regs_o = act;

    AST_NO_DRIVE_UNSELECTED: assert property (@(posedge pclk) disable iff (!rst_n)
        !sel_i |-> !bus_oe); // R5

    AST_QUIET_WHEN_OFF: assert property (@(posedge pclk) disable iff (!rst_n)
        !bus_oe |-> (bus_o == '0)); // R4
endmodule

// File: tb/ppt_port_tb.sv
module ppt_port_tb;
    localparam int DW   = 8;
    localparam int NREG = 6;

    logic               pclk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sel_i = 1'b0;
    logic               rnw_i = 1'b0;
    logic [DW-1:0]      bus_i = '0;
    logic [DW-1:0]      bus_o;
    logic               bus_oe;
    logic               upd_i = 1'b0;
    logic [NREG*DW-1:0] regs_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] mb [NREG];
    logic [7:0] ma [NREG];

    always #10 pclk = ~pclk;

    ppt_port #(.DW(DW), .NREG(NREG)) u_dut (
        .pclk(pclk), .rst_n(rst_n), .sel_i(sel_i), .rnw_i(rnw_i),
        .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe), .upd_i(upd_i),
        .regs_o(regs_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pack_act();
        logic [63:0] r = '0;
        for (int k = 0; k < NREG; k++) r[k*8 +: 8] = ma[k];
        return r;
    endfunction

    function automatic logic [7:0] model_rd(input logic [7:0] a);
        return (a < NREG) ? mb[a] : 8'h00;
    endfunction

    task automatic clear_model();
        for (int k = 0; k < NREG; k++) begin mb[k] = 8'h00; ma[k] = 8'h00; end
    endtask

    // abort_at: 0 none, 2 select low at edge 2, 3 select low at edge 3
    task automatic access(input bit rd, input logic [7:0] a, input logic [7:0] d, input int abort_at);
        sel_i = 1'b1; rnw_i = rd; bus_i = a;
        @(posedge pclk); @(negedge pclk);
        chk("R4 oe low in address phase", bus_oe, 0);
        rnw_i = ~rd;   // R1: direction already latched
        if (abort_at == 2) begin
            sel_i = 1'b0;
            #1 chk("R5 oe low after early abort", bus_oe, 0);
            @(posedge pclk); @(negedge pclk);
        end else begin
            bus_i = rd ? 8'($urandom) : d;
            @(posedge pclk); @(negedge pclk);
            if (rd) begin
                chk("R3 oe high in read data phase", bus_oe, 1);
                chk("R3 R7 R8 read data", bus_o, model_rd(a));
            end else begin
                chk("R4 oe low during write", bus_oe, 0);
                chk("R4 bus_o quiet during write", bus_o, 0);
            end
            if (abort_at == 3) begin
                sel_i = 1'b0;
                #1 chk("R5 oe drops with select", bus_oe, 0);
                @(posedge pclk); @(negedge pclk);
            end else begin
                @(posedge pclk); @(negedge pclk);
                sel_i = 1'b0;
                if (!rd && a < NREG) mb[a] = d;  // R2 commit at third edge
                chk("R3 oe low after access", bus_oe, 0);
                @(posedge pclk); @(negedge pclk);
            end
        end
        sel_i = 1'b0;
        chk("R6 active unchanged without update", regs_o, pack_act());
    endtask

    task automatic do_update();
        upd_i = 1'b1;
        @(posedge pclk); @(negedge pclk);
        upd_i = 1'b0;
        for (int k = 0; k < NREG; k++) ma[k] = mb[k];
        chk("R6 R10 active after update", regs_o, pack_act());
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd7);
        clear_model();
        repeat (3) @(negedge pclk);
        rst_n = 1'b1;
        @(negedge pclk);
        chk("R9 regs clear after reset", regs_o, 0);
        chk("R9 oe low after reset", bus_oe, 0);
        for (int a = 0; a < NREG; a++) access(1, 8'(a), 8'h00, 0);

        // R7: staged write visible on read, not on regs_o
        access(0, 8'd2, 8'hA5, 0);
        access(1, 8'd2, 8'h00, 0);
        do_update();
        chk("R10 register 2 field", regs_o[23:16], 8'hA5);
        // R8: out of range
        access(0, 8'd200, 8'h3C, 0);
        access(0, 8'd6, 8'h3C, 0);
        access(1, 8'd200, 8'h00, 0);
        access(1, 8'd7, 8'h00, 0);
        // R5: aborts at each edge leave the buffer alone
        access(0, 8'd1, 8'h77, 3);
        access(0, 8'd1, 8'h66, 2);
        access(1, 8'd1, 8'h00, 0);
        access(1, 8'd2, 8'h00, 3);

        for (int i = 0; i < 400; i++) begin
            int op;
            logic [7:0] a;
            op = int'($urandom % 8);
            a  = 8'($urandom % (NREG + 4));
            case (op)
                0, 1, 2: access(0, a, 8'($urandom), 0);
                3, 4, 5: access(1, a, 8'h00, 0);
                6:       do_update();
                default: access(1'($urandom), a, 8'($urandom), 2 + int'($urandom % 2));
            endcase
        end

        // R9: reset in the middle of an access
        access(0, 8'd3, 8'h5A, 0);
        do_update();
        sel_i = 1'b1; rnw_i = 1'b1; bus_i = 8'd3;
        @(posedge pclk); @(negedge pclk);
        rst_n = 1'b0; sel_i = 1'b0;
        @(posedge pclk); @(negedge pclk);
        rst_n = 1'b1;
        clear_model();
        chk("R9 regs clear after second reset", regs_o, 0);
        chk("R9 oe low after second reset", bus_oe, 0);
        access(1, 8'd3, 8'h00, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule